// File: doc/BRIEF.md
# Address Watchpoint Unit

This block compares every memory access and instruction fetch a core issues against four programmable watch slots. Each slot has an address register and a 4-bit configuration field. The field sets which access kinds the slot reacts to and how many bytes around its address it covers. When an enabled slot sees a valid access whose byte range touches the slot's range, the block raises a one-cycle trap pulse and records the slot in a sticky status register.

Software reaches the block through a register port indexed by a 3-bit number. Indices 0 to 3 hold the slot addresses, index 6 is the status register and index 7 is the control register. The control register holds two enable bits per slot: a local one at bit 2n and a global one at bit 2n+1. A task-switch strobe clears every local enable and leaves the global ones alone. The single-step and task-switch status flags and the two slowdown control bits are storage only. The block does not act on them.

Top module: `watch_unit`

## Requirements
- R1: Register indices 0 to 3 read back the last value written to them. Indices 4 and 5 always read zero, and writes to them change nothing.
- R2: Control register (index 7) bits 15:10 always read zero. Every other control bit reads back as written, unless R9 clears it.
- R3: Status register (index 6) bits set in 0xFFFF0FF0 always read one. A write stores bits 3:0 and 15:12, and those bits read back as written.
- R4: Slot n's access-type field is control bits [16+4n+1 : 16+4n]. Access kind encoding: 0 is fetch, 1 is read, 2 is write, 3 is idle. Type 00 matches fetches only. Type 01 matches writes only. Type 11 matches reads and writes. Type 10 matches nothing.
- R5: Slot n's length field is control bits [16+4n+3 : 16+4n+2]. Code 00 covers 1 byte, 01 covers 2, 11 covers 4 and 10 covers 8. The slot's range starts at its address with the low bits cleared to that length. An access of size code s covers 2^s bytes from its address. A hit needs the two ranges to overlap.
- R6: A slot is armed when its local or global enable is set. An unarmed slot never hits.
- R7: The trap output is high in the cycle after a clock edge at which a valid access hit at least one armed slot. It is low in every other cycle. An access with the valid strobe low never hits.
- R8: At a hit edge, status bit n is set for every slot n that hit. Status bits stay set until software writes the status register. If a status write and a hit happen at the same edge, the hit bits are ORed onto the written value.
- R9: At an edge with task-switch high, control bits 0, 2, 4 and 6 are cleared and bits 1, 3, 5 and 7 are kept. This clearing also applies on top of a control write at the same edge.
- R10: A control write affects accesses from the next cycle on. Writing zero leaves every later access without a trap.
- R11: After reset, every register reads zero except status, which reads 0xFFFF0FF0, and trap is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 3 | Register number for read and write |
| reg_wr | input | 1 | Write strobe for the register at reg_idx |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at reg_idx (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access byte address |
| acc_size | input | 2 | Access size as log2 of byte count |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 idle |
| task_switch | input | 1 | Clears all local enables |
| trap | output | 1 | One-cycle watchpoint trap pulse |
| status_out | output | 32 | Current status register value |

## Verification
The bench probes addresses one byte outside each length's range, and accesses that only straddle a range boundary. A design that masked the wrong address bits, or compared start addresses instead of overlapping ranges, would miss those hits or fire on those misses. It tries every access kind against every type code, including the reserved one. A wrong kind decoder would trap on fetches in data mode or on anything in never mode. It drives same-edge collisions of a status write with a hit, and of a control write with a task switch. A wrong priority there would lose the hit bits or leave local enables set. It also accesses right after a zero control write, where a design with stale enables would still trap.

// File: rtl/watch_pkg.sv
package watch_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int REG_W     = 32;
    localparam int IDX_W     = 3;
    localparam int FIELD_LSB = 16;
    localparam int FIELD_W   = 4;

    localparam logic [IDX_W-1:0] IDX_STATUS = 3'd6;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd7;

    localparam logic [REG_W-1:0] STAT_FIXED_ONES = 32'hFFFF0FF0;
    localparam logic [REG_W-1:0] CTRL_KEEP       = 32'hFFFF03FF;
    localparam logic [REG_W-1:0] LOCAL_EN_MASK   = 32'h00000055;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_IDLE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        RW_EXEC  = 2'b00,
        RW_WRITE = 2'b01,
        RW_NEVER = 2'b10,
        RW_DATA  = 2'b11
    } rw_sel_e;

    typedef struct packed {
        logic [1:0] len;
        rw_sel_e    rw;
        logic       en_local;
        logic       en_global;
    } slot_cfg_t;

    function automatic slot_cfg_t slot_cfg(input logic [REG_W-1:0] ctrl, input int n);
        slot_cfg_t c;
        logic [FIELD_W-1:0] f;
        f           = ctrl[FIELD_LSB + FIELD_W*n +: FIELD_W];
        c.rw        = rw_sel_e'(f[1:0]);
        c.len       = f[3:2];
        c.en_local  = ctrl[2*n];
        c.en_global = ctrl[2*n + 1];
        return c;
    endfunction

    // bytes covered minus one, per length code
    function automatic logic [2:0] len_span(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            2'b11:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [2:0] size_span(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic kind_allowed(input rw_sel_e rw, input acc_kind_e k);
        case (rw)
            RW_EXEC:  return k == KIND_FETCH;
            RW_WRITE: return k == KIND_WRITE;
            RW_DATA:  return (k == KIND_READ) || (k == KIND_WRITE);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/watch_slot_cmp.sv
module watch_slot_cmp
    import watch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  slot_cfg_t           cfg,
    input  logic [ADDR_W-1:0]   slot_addr,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_size,
    input  acc_kind_e           acc_kind,
    output logic                hit
);
    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0] slot_lo, slot_hi, acc_lo, acc_hi;
    logic           armed, kind_ok, overlap;

    always_comb begin
        slot_lo = {1'b0, slot_addr & ~ADDR_W'(len_span(cfg.len))};
        slot_hi = slot_lo + AW1'(len_span(cfg.len));
        acc_lo  = {1'b0, acc_addr};
        acc_hi  = acc_lo + AW1'(size_span(acc_size));
        armed   = cfg.en_local | cfg.en_global;
        kind_ok = kind_allowed(cfg.rw, acc_kind);
        overlap = (acc_lo <= slot_hi) && (slot_lo <= acc_hi);
        hit     = acc_valid && armed && kind_ok && overlap;
    end
endmodule

// File: rtl/watch_regs.sv
module watch_regs
    import watch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 task_switch,
    input  logic [NUM_SLOTS-1:0] slot_hits,
    output logic [ADDR_W-1:0]    addr_q [NUM_SLOTS],
    output logic [REG_W-1:0]     ctrl_q,
    output logic [REG_W-1:0]     stat_val,
    output logic [REG_W-1:0]     rdata
);
    logic [REG_W-1:0] stat_q, stat_d, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && reg_idx == IDX_CTRL)
            ctrl_d = reg_wdata & CTRL_KEEP;
        if (task_switch)
            ctrl_d = ctrl_d & ~LOCAL_EN_MASK;
    end

    always_comb begin
        stat_d = stat_q;
        if (reg_wr && reg_idx == IDX_STATUS)
            stat_d = reg_wdata & ~STAT_FIXED_ONES;
        stat_d[NUM_SLOTS-1:0] = stat_d[NUM_SLOTS-1:0] | slot_hits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++)
                addr_q[i] <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
            for (int i = 0; i < NUM_SLOTS; i++)
                if (reg_wr && reg_idx == IDX_W'(i))
                    addr_q[i] <= reg_wdata[ADDR_W-1:0];
        end
    end

    assign stat_val = stat_q | STAT_FIXED_ONES;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (reg_idx == IDX_W'(i))
                rdata = REG_W'(addr_q[i]);
        if (reg_idx == IDX_STATUS)
            rdata = stat_val;
        if (reg_idx == IDX_CTRL)
            rdata = ctrl_q;
    end
endmodule

// File: rtl/watch_unit.sv
module watch_unit
    import watch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_idx,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              task_switch,
    output logic              trap,
    output logic [31:0]       status_out
);
    logic [ADDR_W-1:0]    addr_q [NUM_SLOTS];
    logic [REG_W-1:0]     ctrl_q;
    logic [NUM_SLOTS-1:0] hits;
    acc_kind_e            kind;

    assign kind = acc_kind_e'(acc_kind);

    watch_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_idx     (reg_idx),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .task_switch (task_switch),
        .slot_hits   (hits),
        .addr_q      (addr_q),
        .ctrl_q      (ctrl_q),
        .stat_val    (status_out),
        .rdata       (reg_rdata)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_cfg_t cfg_s;
        assign cfg_s = slot_cfg(ctrl_q, s);
        watch_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .cfg       (cfg_s),
            .slot_addr (addr_q[s]),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .acc_kind  (kind),
            .hit       (hits[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) trap <= 1'b0;
        else     trap <= |hits;
    end
endmodule

// File: rtl/watch_unit_chk.sv
module watch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  reg_idx,
    input logic        reg_wr,
    input logic [7:0]  wdata_lo,
    input logic        acc_valid,
    input logic        task_switch,
    input logic        trap,
    input logic [31:0] status_out,
    input logic [31:0] ctrl_q
);
    p_trap_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        trap |-> $past(acc_valid));

    p_trap_needs_armed_r6: assert property (@(posedge clk) disable iff (rst)
        trap |-> ($past(ctrl_q[7:0]) != 8'h00));

    p_trap_marks_status_r8: assert property (@(posedge clk) disable iff (rst)
        trap |-> (status_out[3:0] != 4'h0));

    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && reg_idx == 3'd6) |->
            ((status_out[3:0] & $past(status_out[3:0])) == $past(status_out[3:0])));

    p_task_clears_local_r9: assert property (@(posedge clk) disable iff (rst)
        $past(task_switch) |-> ((ctrl_q & 32'h55) == 32'h0));

    p_zero_ctrl_disarms_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_idx == 3'd7 && wdata_lo == 8'h00) |-> ##2 !trap);
endmodule

bind watch_unit watch_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_idx     (reg_idx),
    .reg_wr      (reg_wr),
    .wdata_lo    (reg_wdata[7:0]),
    .acc_valid   (acc_valid),
    .task_switch (task_switch),
    .trap        (trap),
    .status_out  (status_out),
    .ctrl_q      (ctrl_q)
);

// File: tb/watch_unit_test.sv
module watch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_idx = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = 2'd3;
    logic        task_switch = 1'b0;
    logic        trap;
    logic [31:0] status_out;

    int  checks = 0;
    int  errors = 0;
    bit  run = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    watch_unit uut (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
        .task_switch(task_switch), .trap(trap), .status_out(status_out)
    );

    // ---------------- behavioural reference model ----------------
    longint unsigned m_addr [4];
    logic [31:0]     m_ctrl;
    logic [31:0]     m_stat;
    bit              m_trap;

    function automatic bit m_hit(int n);
        int unsigned fld, rw, lcode;
        longint unsigned bytes, lo, hi, alo, ahi;
        bit kind_ok;
        if (!(m_ctrl[2*n] || m_ctrl[2*n+1]) || !acc_valid) return 0;
        fld   = (m_ctrl >> (16 + 4*n)) & 32'hF;
        rw    = fld & 3;
        lcode = fld >> 2;
        case (lcode)
            0: bytes = 1;
            1: bytes = 2;
            3: bytes = 4;
            default: bytes = 8;
        endcase
        case (rw)
            0: kind_ok = (acc_kind == 2'd0);
            1: kind_ok = (acc_kind == 2'd2);
            3: kind_ok = (acc_kind == 2'd1) || (acc_kind == 2'd2);
            default: kind_ok = 0;
        endcase
        lo  = m_addr[n] - (m_addr[n] % bytes);
        hi  = lo + bytes - 1;
        alo = acc_addr;
        ahi = alo + (longint'(1) << acc_size) - 1;
        return kind_ok && (alo <= hi) && (lo <= ahi);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_addr[i]) m_addr[i] = 0;
            m_ctrl = 0; m_stat = 0; m_trap = 0;
        end else begin
            logic [3:0] h;
            for (int i = 0; i < 4; i++) h[i] = m_hit(i);
            m_trap = (h != 0);
            if (reg_wr && reg_idx < 4) m_addr[reg_idx] = reg_wdata;
            if (reg_wr && reg_idx == 6) m_stat = reg_wdata & 32'h0000F00F;
            m_stat = m_stat | {28'h0, h};
            if (reg_wr && reg_idx == 7) m_ctrl = reg_wdata & 32'hFFFF03FF;
            if (task_switch) m_ctrl = m_ctrl & ~32'h55;
        end
    end

    function automatic logic [31:0] m_read();
        if (reg_idx < 4) return m_addr[reg_idx][31:0];
        if (reg_idx == 6) return m_stat | 32'hFFFF0FF0;
        if (reg_idx == 7) return m_ctrl;
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run && !rst) begin
            chk("R7", {31'b0, trap}, {31'b0, m_trap});
            chk("R8", status_out, m_stat | 32'hFFFF0FF0);
            chk("R1", reg_rdata, m_read());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic op(input logic [2:0] idx, input logic wr, input logic [31:0] wd,
                      input logic v, input logic [31:0] a, input logic [1:0] sz,
                      input logic [1:0] k, input logic ts);
        @(posedge clk); #2;
        reg_idx = idx; reg_wr = wr; reg_wdata = wd;
        acc_valid = v; acc_addr = a; acc_size = sz; acc_kind = k;
        task_switch = ts;
    endtask

    task automatic wreg(input logic [2:0] idx, input logic [31:0] d);
        op(idx, 1'b1, d, 1'b0, 32'h0, 2'd0, 2'd3, 1'b0);
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        op(idx, 1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 2'd3, 1'b0);
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic probe(input logic v, input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] k, input logic exp, input string tag);
        op(3'd6, 1'b0, 32'h0, v, a, sz, k, 1'b0);
        op(3'd6, 1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 2'd3, 1'b0);
        @(negedge clk);
        chk(tag, {31'b0, trap}, {31'b0, exp});
    endtask

    function automatic logic [31:0] fld(int n, int len, int rw);
        return 32'(((len << 2) | rw) << (16 + 4*n));
    endfunction

    localparam logic [1:0] FE = 2'd0, RD = 2'd1, WR = 2'd2;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0; run = 1;

        // R11: reset state
        rd(3'd6, 32'hFFFF0FF0, "R11");
        rd(3'd7, 32'h0, "R11");
        rd(3'd0, 32'h0, "R11");
        chk("R11", {31'b0, trap}, 32'h0);

        // R1: address registers and unused indices
        wreg(3'd0, 32'h0000_1000);
        wreg(3'd1, 32'h0000_2006);
        wreg(3'd2, 32'h0000_2006);
        wreg(3'd3, 32'h0000_3000);
        rd(3'd0, 32'h1000, "R1");
        rd(3'd1, 32'h2006, "R1");
        rd(3'd3, 32'h3000, "R1");
        wreg(3'd4, 32'hDEAD_BEEF);
        rd(3'd4, 32'h0, "R1");
        wreg(3'd5, 32'h1234_5678);
        rd(3'd5, 32'h0, "R1");

        // R2: reserved control bits
        wreg(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, 32'hFFFF_03FF, "R2");
        wreg(3'd7, 32'h0);

        // R3: status reserved bits and storable bits
        wreg(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, 32'hFFFF_FFFF, "R3");
        wreg(3'd6, 32'h1234_5678);
        rd(3'd6, 32'hFFFF_5FF8, "R3");
        wreg(3'd6, 32'h0);
        rd(3'd6, 32'hFFFF_0FF0, "R3");

        // R4: access types on slot 0 (addr 0x1000, local enable)
        wreg(3'd7, 32'h1 | fld(0, 0, 0));
        probe(1, 32'h1000, 2'd0, FE, 1, "R4");
        probe(1, 32'h1000, 2'd0, RD, 0, "R4");
        probe(1, 32'h1000, 2'd0, WR, 0, "R4");
        rd(3'd6, 32'hFFFF_0FF1, "R8");
        wreg(3'd7, 32'h1 | fld(0, 0, 1));
        probe(1, 32'h1000, 2'd0, WR, 1, "R4");
        probe(1, 32'h1000, 2'd0, RD, 0, "R4");
        probe(1, 32'h1000, 2'd0, FE, 0, "R4");
        wreg(3'd7, 32'h1 | fld(0, 0, 3));
        probe(1, 32'h1000, 2'd0, RD, 1, "R4");
        probe(1, 32'h1000, 2'd0, WR, 1, "R4");
        probe(1, 32'h1000, 2'd0, FE, 0, "R4");
        wreg(3'd7, 32'h1 | fld(0, 0, 2));
        probe(1, 32'h1000, 2'd0, RD, 0, "R4");
        probe(1, 32'h1000, 2'd0, WR, 0, "R4");
        probe(1, 32'h1000, 2'd0, FE, 0, "R4");

        // R5: lengths on slot 1 (addr 0x2006, global enable)
        wreg(3'd7, 32'h8 | fld(1, 2, 3));
        probe(1, 32'h2000, 2'd0, RD, 1, "R5");
        probe(1, 32'h2008, 2'd0, RD, 0, "R5");
        probe(1, 32'h1FFF, 2'd1, RD, 1, "R5");
        wreg(3'd7, 32'h8 | fld(1, 3, 3));
        probe(1, 32'h2003, 2'd1, RD, 1, "R5");
        probe(1, 32'h2002, 2'd1, RD, 0, "R5");
        probe(1, 32'h2008, 2'd2, RD, 0, "R5");
        wreg(3'd7, 32'h8 | fld(1, 1, 3));
        probe(1, 32'h2004, 2'd3, WR, 1, "R5");
        probe(1, 32'h2005, 2'd0, RD, 0, "R5");
        probe(1, 32'h2008, 2'd0, RD, 0, "R5");
        wreg(3'd7, 32'h8 | fld(1, 0, 3));
        probe(1, 32'h2006, 2'd0, RD, 1, "R5");
        probe(1, 32'h2007, 2'd0, RD, 0, "R5");
        probe(1, 32'h2005, 2'd1, RD, 1, "R5");

        // R6: arming
        wreg(3'd7, fld(1, 2, 3));
        probe(1, 32'h2000, 2'd0, RD, 0, "R6");
        wreg(3'd7, 32'h4 | fld(1, 2, 3));
        probe(1, 32'h2000, 2'd0, RD, 1, "R6");

        // R8: multiple hits, stickiness, same-edge write
        wreg(3'd6, 32'h0);
        wreg(3'd7, 32'h14 | fld(1, 2, 3) | fld(2, 0, 3));
        probe(1, 32'h2006, 2'd0, RD, 1, "R8");
        rd(3'd6, 32'hFFFF_0FF6, "R8");
        probe(1, 32'h9000, 2'd0, RD, 0, "R8");
        rd(3'd6, 32'hFFFF_0FF6, "R8");
        op(3'd6, 1'b1, 32'h1, 1'b1, 32'h2006, 2'd0, RD, 1'b0);
        rd(3'd6, 32'hFFFF_0FF7, "R8");

        // R9: task switch
        wreg(3'd7, 32'hFF | fld(1, 2, 3) | fld(2, 0, 3));
        op(3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 2'd3, 1'b1);
        rd(3'd7, 32'h03B0_00AA, "R9");
        op(3'd7, 1'b1, 32'h0000_000F, 1'b0, 32'h0, 2'd0, 2'd3, 1'b1);
        rd(3'd7, 32'h0000_000A, "R9");

        // R10: zero control disarms at once
        wreg(3'd7, 32'h4 | fld(1, 2, 3));
        wreg(3'd7, 32'h0);
        probe(1, 32'h2006, 2'd0, RD, 0, "R10");

        // R7: valid low ignored, trap is a single pulse
        wreg(3'd7, 32'h4 | fld(1, 2, 3));
        probe(0, 32'h2006, 2'd0, RD, 0, "R7");
        probe(1, 32'h2006, 2'd0, RD, 1, "R7");
        @(negedge clk);
        chk("R7", {31'b0, trap}, 32'h0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule